// File: doc/BRIEF.md
# Single-Wire Pulse-Width LED Chain Encoder

This block turns a stream of colour bytes into the self-clocked waveform that a daisy chain of addressable RGB LEDs expects on one data wire. Every bit gets a slot of fixed length. The line rises at the start of each slot, and the point where it falls again tells the LED whether the bit is a zero or a one. There is no clock line. When a frame ends, the line stays low long enough for every LED in the chain to latch the colour it has received.

Bytes arrive over a valid/ready handshake. An upstream source sends three bytes per LED, first green, then red, then blue, eight bits each. The encoder serialises each byte most significant bit first. It takes the next byte in the last cycle of the current byte, so a continuous stream leaves no gap between slots. A frame can close in three ways: the upstream marks a byte as the last of the frame, the upstream marks a byte as the first of a new frame, or no byte is ready at a byte boundary. In every case the encoder runs the latch interval and holds `busy` high until that interval is over. All timing values are parameters counted in clock cycles. The defaults of 20, 6, 10 and 800 cycles give an 800 kHz bit rate and a 50 µs latch at 16 MHz.

Top module: `led_chain_encoder`

## Requirements
- R1: After reset, `led_out` is 0, `busy` is 0 and `in_ready` is 1.
- R2: Bytes go out in the order they were accepted, and bit 7 of each byte is sent first.
- R3: A 0 bit drives `led_out` high for exactly ZERO_HIGH_CYC cycles at the start of its slot.
- R4: A 1 bit drives `led_out` high for exactly ONE_HIGH_CYC cycles. Rising edges inside a frame are exactly SLOT_CYC cycles apart.
- R5: When a byte is offered before the current byte ends, it is accepted in the final cycle of the current byte. The first rising edge of the new byte then comes exactly SLOT_CYC cycles after the previous rising edge.
- R6: When no byte is accepted at a byte boundary, `led_out` stays low and `busy` stays high. `busy` falls SLOT_CYC - H + LATCH_CYC - 1 cycles after the final falling edge, where H is the high time of the final bit.
- R7: After a byte accepted with `in_last` = 1, no further byte is accepted until the latch interval has completed, even if one is offered.
- R8: A byte offered with `in_first` = 1 while a frame is in progress is not accepted at the byte boundary. The latch interval runs first, and the byte is accepted once the encoder is idle.
- R9: While `busy` is 1, `in_ready` is 1 only in the final cycle of a byte's last slot. That cycle is SLOT_CYC - 2 cycles after the rising edge of the last bit as seen on `led_out`.
- R10: `led_out` comes from a register and is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Encoder takes the offered byte at this edge |
| in_data | input | BYTE_W | Colour byte, most significant bit sent first |
| in_first | input | 1 | Byte opens a new frame |
| in_last | input | 1 | Byte closes the current frame |
| led_out | output | 1 | Registered serial line to the LED chain |
| busy | output | 1 | Frame or latch interval in progress |

## Verification
On every cycle, the assertions check that the line stays low throughout the latch interval and while idle, that no high pulse lasts longer than the one-bit width, and that a byte is taken mid-frame only at a byte boundary and never after an end-of-frame byte. The bench decodes the waveform by measuring pulse widths. A full sweep of all 256 byte values shows that the bit order is correct and that the slot period holds with no gap across byte boundaries. Only the bench's scenarios can show the exact latch length, the automatic frame close when the upstream stalls, and the latch forced by a start-of-frame byte.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_LATCH = 2'd2
    } enc_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/led_cycle_timer.sv
module led_cycle_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign count = cnt_q;
    assign done  = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the counter never runs past the active limit, so slots keep their length
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (cnt_q <= limit) || $changed(limit));

endmodule

// File: rtl/led_byte_shifter.sv
module led_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_last,
    output logic              msb,
    output logic              final_bit,
    output logic              last_byte
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic [BYTE_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last_q;

    assign msb       = shreg_q[BYTE_W-1];
    assign final_bit = (idx_q == '0);
    assign last_byte = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            idx_q   <= '0;
            last_q  <= 1'b0;
        end else if (load) begin
            shreg_q <= din;
            idx_q   <= IDX_W'(BYTE_W - 1);
            last_q  <= din_last;
        end else if (shift) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            idx_q   <= idx_q - 1'b1;
        end
    end

    // R2: the byte under transmission only changes on a load or a shift step
    p_byte_held_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(shreg_q));

    // R2: a shift never happens on the final bit of a byte
    p_no_shift_past_end_r2: assert property (@(posedge clk) disable iff (rst)
        shift |-> !final_bit);

endmodule

// File: rtl/led_chain_encoder.sv
module led_chain_encoder
    import led_enc_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int SLOT_CYC      = 20,
    parameter int ZERO_HIGH_CYC = 6,
    parameter int ONE_HIGH_CYC  = 10,
    parameter int LATCH_CYC     = 800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              led_out,
    output logic              busy
);
    localparam int unsigned CNT_MAX = max2(SLOT_CYC, LATCH_CYC);
    localparam int          CNT_W   = $clog2(CNT_MAX + 1);

    enc_state_e       state_q, state_d;
    logic [CNT_W-1:0] count, limit, high_len;
    logic             done, msb, final_bit, last_byte;
    logic             byte_end, accept, shift, led_q;

    assign byte_end = (state_q == ST_SEND) && done && final_bit;
    assign in_ready = (state_q == ST_IDLE) || (byte_end && !last_byte && !in_first);
    assign accept   = in_valid && in_ready;
    assign shift    = (state_q == ST_SEND) && done && !final_bit;
    assign limit    = (state_q == ST_LATCH) ? CNT_W'(LATCH_CYC - 1) : CNT_W'(SLOT_CYC - 1);
    assign high_len = msb ? CNT_W'(ONE_HIGH_CYC) : CNT_W'(ZERO_HIGH_CYC);
    assign busy     = (state_q != ST_IDLE);
    assign led_out  = led_q;

    led_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q == ST_IDLE),
        .limit (limit),
        .count (count),
        .done  (done)
    );

    led_byte_shifter #(.BYTE_W(BYTE_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .shift     (shift),
        .din       (in_data),
        .din_last  (in_last),
        .msb       (msb),
        .final_bit (final_bit),
        .last_byte (last_byte)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SEND;
            ST_SEND:  if (byte_end && !accept) state_d = ST_LATCH;
            ST_LATCH: if (done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            led_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            led_q   <= (state_q == ST_SEND) && (count < high_len);
        end
    end

    // checker counter: length of the current high pulse
    logic [CNT_W-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (rst) hi_run_q <= '0;
        else     hi_run_q <= led_q ? hi_run_q + 1'b1 : '0;
    end

    p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !led_out);

    p_latch_low_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LATCH) |=> !led_out);

    p_pulse_max_r4: assert property (@(posedge clk) disable iff (rst)
        hi_run_q <= CNT_W'(ONE_HIGH_CYC));

    p_accept_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && busy) |-> (done && final_bit && state_q == ST_SEND));

    p_last_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (byte_end && last_byte) |=> (state_q == ST_LATCH));

    p_first_waits_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && in_valid && in_first) |-> !in_ready);

endmodule

// File: tb/led_chain_encoder_bench.sv
`timescale 1ns/100ps
module led_chain_encoder_bench;
    localparam int BW = 8;
    localparam int S  = 8;
    localparam int T0 = 2;
    localparam int T1 = 5;
    localparam int L  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic in_last  = 1'b0;
    logic [BW-1:0] in_data = '0;
    logic in_ready, led_out, busy;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;

    logic [BW-1:0] exp_q[$];
    int frames_seen = 0;

    always #2 clk = ~clk;

    led_chain_encoder #(
        .BYTE_W(BW), .SLOT_CYC(S), .ZERO_HIGH_CYC(T0),
        .ONE_HIGH_CYC(T1), .LATCH_CYC(L)
    ) u_led_chain_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .led_out(led_out), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waveform monitor, sampling on the falling clock edge
    logic prev_led = 1'b0;
    logic prev_busy = 1'b0;
    int hi_w = 0, last_h = 0, low_busy = 0, since_rise = 0;
    int bitcnt = 0;
    bit have_rise = 1'b0;
    logic [BW-1:0] asm_byte = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (led_out && !prev_led) begin
                if (have_rise)
                    check(since_rise == S, "R4/R5 slot period", since_rise, S);
                have_rise = 1'b1;
                since_rise = 0;
                hi_w = 0;
                low_busy = 0;
            end
            if (led_out) hi_w++;
            if (!led_out && prev_led) begin
                last_h = hi_w;
                if (hi_w == T0) begin
                    check(1'b1, "R3 zero width", hi_w, T0);
                    asm_byte = {asm_byte[BW-2:0], 1'b0};
                end else begin
                    check(hi_w == T1, "R4 one width", hi_w, T1);
                    asm_byte = {asm_byte[BW-2:0], 1'b1};
                end
                bitcnt++;
                if (bitcnt == BW) begin
                    bitcnt = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected byte", asm_byte, -1);
                    end else begin
                        logic [BW-1:0] e;
                        e = exp_q.pop_front();
                        check(asm_byte == e, "R2 byte content", asm_byte, e);
                    end
                end
            end
            if (busy && in_ready)
                check(since_rise == S - 2, "R9 ready position", since_rise, S - 2);
            if (!led_out && busy && have_rise) low_busy++;
            if (!busy && prev_busy) begin
                frames_seen++;
                check(low_busy == S - last_h + L - 1, "R6 latch length",
                      low_busy, S - last_h + L - 1);
                check(bitcnt == 0, "R6 frame ends on byte boundary", bitcnt, 0);
                have_rise = 1'b0;
                low_busy = 0;
            end
            if (!busy) check(!led_out, "R10 idle line low", led_out, 0);
            since_rise++;
            prev_led = led_out;
            prev_busy = busy;
        end
    end

    task automatic push(input logic [BW-1:0] d, input bit f, input bit l);
        in_valid = 1'b1;
        in_data  = d;
        in_first = f;
        in_last  = l;
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                exp_q.push_back(d);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int exp_frames;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(led_out == 1'b0, "R1 reset line", led_out, 0);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        @(negedge clk);
        mon_en = 1'b1;

        // R2/R5: all byte values back-to-back in one frame
        for (int v = 0; v < 256; v++)
            push(BW'(v), v == 0, v == 255);
        wait_idle();
        exp_frames = 1;
        check(frames_seen == exp_frames, "R5 single frame for stream", frames_seen, exp_frames);

        // R6: stalled upstream closes each frame by itself
        for (int k = 0; k < 3; k++) begin
            push(BW'(8'hA5 ^ k), 1'b0, 1'b0);
            repeat (S * BW + L + 10) @(negedge clk);
        end
        exp_frames += 3;
        check(frames_seen == exp_frames, "R6 auto latch count", frames_seen, exp_frames);

        // R7: end-of-frame byte followed at once by another
        push(8'h3C, 1'b0, 1'b1);
        push(8'hC3, 1'b0, 1'b1);
        wait_idle();
        exp_frames += 2;
        check(frames_seen == exp_frames, "R7 latch after last byte", frames_seen, exp_frames);

        // R8: start-of-frame byte offered mid-frame
        push(8'hF0, 1'b1, 1'b0);
        push(8'h0F, 1'b0, 1'b0);
        push(8'h81, 1'b1, 1'b1);
        wait_idle();
        exp_frames += 2;
        check(frames_seen == exp_frames, "R8 latch before new frame", frames_seen, exp_frames);

        check(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule